// File: doc/BRIEF.md
# Programmable MMIO Range Router

This block decides where a processor memory-mapped access should go. Software programs a small set of direct windows. Each window is described by three 64-bit registers, placed one after another 8 bytes apart: a start register, a size-mask register and a destination register. The windows sit in a register bank starting at a fixed offset. An incoming lookup address is compared against every enabled window in parallel. The block answers with a hit flag and the number of the downstream port that owns the address. Moving the transaction itself to that port is left to the logic around the block.

Registers accept either a full 64-bit write or a 32-bit write to one half. Address bit 2 picks which half a 32-bit access touches. When any register of a window is written, that window's decoded form is rebuilt. The decoded form holds the enable, the page-aligned start, the byte size and the port. Until the rebuild is finished, the window stops matching, so a half-programmed window can never claim traffic. The window start always lands in the topmost 4 GiB of the 64-bit space. The size is the two's complement of the low 32 bits of the mask. The destination is the route value reduced to the port count.

Top module: `mmio_range_router`

## Requirements
- R1: After reset every register in the bank reads as zero, and no lookup address produces a hit.
- R2: A 64-bit write inside the register window replaces the whole register. A 64-bit read returns it unchanged.
- R3: A 32-bit write with address bit 2 clear replaces bits 31:0 with the low 32 data bits and keeps bits 63:32. With bit 2 set, it replaces bits 63:32 with the low 32 data bits and keeps bits 31:0.
- R4: A 32-bit read returns, in bits 31:0, the low half when address bit 2 is clear and the high half when it is set. Bits 63:32 read as zero.
- R5: Window register k of range r sits at byte offset 0x300 + 8·(3r+k), with k = 0 start, 1 mask, 2 route. Writes outside the 12-register window change no register and no mapping. Reads outside the window return zero.
- R6: A range can match only when bit 0 of its start register is 1 and its computed size is non-zero.
- R7: A range's size is (~mask[31:0] + 1) taken to 32 bits with bits 11:0 cleared. An address matches when start ≤ address < start + size.
- R8: A range's start is bits 31:12 of the start register, with bits 63:32 forced to all ones and bits 11:0 zero. Bits 63:32 of the start register are ignored for matching.
- R9: A range's port is route[1:0], which is the route value modulo the 4 ports.
- R10: A write to a range's start, mask or route register stops that range from matching in the cycle after the write edge. The new mapping takes effect one clock edge later.
- R11: When several enabled ranges contain the address, the lowest-numbered range sets the port.
- R12: An address that no enabled range contains gives hit = 0 and port = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (12) | Byte offset of the write |
| wr_half | input | 1 | 1 = 32-bit write, 0 = 64-bit write |
| wr_data | input | 64 | Write data (a 32-bit write uses bits 31:0) |
| rd_addr | input | ADDR_W (12) | Byte offset of the read |
| rd_half | input | 1 | 1 = 32-bit read, 0 = 64-bit read |
| rd_data | output | 64 | Read data, combinational |
| lk_addr | input | 64 | Address to route |
| lk_hit | output | 1 | Some enabled range contains lk_addr |
| lk_port | output | PORT_W (2) | Port of the winning range, 0 on a miss |

## Verification
The assertions assume that at most one register write happens per clock. They also assume that the write address and the half-select are stable around the edge, so a register's untouched half can be compared with its previous value. The assertions further assume that a decoded window is only ever rebuilt from whole register values, not from a write still in flight. The bench keeps to this by driving every write for exactly one cycle from the falling edge. It changes lookup and read addresses only away from the rising edge. It samples the rebuilt mapping at the falling edges after the write edge and after the rebuild edge.

// File: rtl/mrr_pkg.sv
package mrr_pkg;

  localparam int DATA_W    = 64;
  localparam int SIZE_W    = 32;
  localparam int PAGE_BITS = 12;

  // Page-aligned window start, pinned into the top 4 GiB.
  function automatic logic [DATA_W-1:0] win_start(input logic [DATA_W-1:0] raw);
    logic [DATA_W-1:0] s;
    s = '1;
    s[SIZE_W-1:0] = raw[SIZE_W-1:0];
    s[PAGE_BITS-1:0] = '0;
    return s;
  endfunction

  // Two's complement of the low mask half, page-aligned.
  function automatic logic [SIZE_W-1:0] win_size(input logic [DATA_W-1:0] mask);
    logic [SIZE_W-1:0] s;
    s = ~mask[SIZE_W-1:0] + SIZE_W'(1);
    s[PAGE_BITS-1:0] = '0;
    return s;
  endfunction

  // start <= a < start + size, computed one bit wider to avoid wrap.
  function automatic logic win_contains(input logic [DATA_W-1:0] a,
                                        input logic [DATA_W-1:0] start,
                                        input logic [SIZE_W-1:0] size);
    logic [DATA_W:0] lo;
    logic [DATA_W:0] hi;
    lo = {1'b0, start};
    hi = lo + {{(DATA_W+1-SIZE_W){1'b0}}, size};
    return ({1'b0, a} >= lo) && ({1'b0, a} < hi);
  endfunction

endpackage

// File: rtl/mrr_regbank.sv
module mrr_regbank
  import mrr_pkg::*;
#(
  parameter int N_RANGES = 4,
  parameter int ADDR_W   = 12,
  parameter int WIN_BASE = 'h300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_half,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_half,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] regs_o [3*N_RANGES],
  output logic [N_RANGES-1:0] touch_o
);

  localparam int N_REGS  = 3 * N_RANGES;
  localparam int IDX_W   = $clog2(N_REGS);
  localparam int WIN_END = WIN_BASE + 8 * N_REGS;

  logic [ADDR_W-1:0] wr_off, rd_off;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic              wr_in_win, rd_in_win, wr_fire;
  logic [N_REGS-1:0] wr_sel;

  assign wr_in_win = (int'(wr_addr) >= WIN_BASE) && (int'(wr_addr) < WIN_END);
  assign rd_in_win = (int'(rd_addr) >= WIN_BASE) && (int'(rd_addr) < WIN_END);
  assign wr_off    = wr_addr - ADDR_W'(WIN_BASE);
  assign rd_off    = rd_addr - ADDR_W'(WIN_BASE);
  assign wr_idx    = wr_off[IDX_W+2:3];
  assign rd_idx    = rd_off[IDX_W+2:3];
  assign wr_fire   = wr_en && wr_in_win;

  for (genvar k = 0; k < N_REGS; k++) begin : g_reg
    assign wr_sel[k] = wr_fire && (wr_idx == IDX_W'(k));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs_o[k] <= '0;
      end else if (wr_sel[k]) begin
        if (!wr_half)
          regs_o[k] <= wr_data;
        else if (wr_addr[2])
          regs_o[k][DATA_W-1:SIZE_W] <= wr_data[SIZE_W-1:0];
        else
          regs_o[k][SIZE_W-1:0] <= wr_data[SIZE_W-1:0];
      end
    end

    AST_LO_WRITE_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[k] && wr_half && !wr_addr[2] |=> regs_o[k][DATA_W-1:SIZE_W] == $past(regs_o[k][DATA_W-1:SIZE_W])); // R3
    AST_HI_WRITE_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[k] && wr_half && wr_addr[2] |=> regs_o[k][SIZE_W-1:0] == $past(regs_o[k][SIZE_W-1:0])); // R3
    AST_OUTSIDE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_in_win |=> $stable(regs_o[k])); // R5
  end

  for (genvar r = 0; r < N_RANGES; r++) begin : g_touch
    assign touch_o[r] = wr_fire && (wr_idx >= IDX_W'(3*r)) && (wr_idx < IDX_W'(3*r+3));
  end

  logic [DATA_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    for (int k = 0; k < N_REGS; k++)
      if (rd_in_win && rd_idx == IDX_W'(k)) rd_word = regs_o[k];
    if (rd_half)
      rd_data = {{(DATA_W-SIZE_W){1'b0}}, rd_addr[2] ? rd_word[DATA_W-1:SIZE_W] : rd_word[SIZE_W-1:0]};
    else
      rd_data = rd_word;
  end

endmodule

// File: rtl/mrr_window.sv
module mrr_window
  import mrr_pkg::*;
#(
  parameter int PORT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              touch,
  input  logic [DATA_W-1:0] start_reg,
  input  logic [DATA_W-1:0] mask_reg,
  input  logic [DATA_W-1:0] route_reg,
  output logic              valid_o,
  output logic [DATA_W-1:0] start_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [PORT_W-1:0] port_o
);

  logic              pending;
  logic [SIZE_W-1:0] new_size;

  assign new_size = win_size(mask_reg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      pending <= 1'b0;
      start_o <= '0;
      size_o  <= '0;
      port_o  <= '0;
    end else if (touch) begin
      valid_o <= 1'b0;   // drop the old mapping before rebuilding
      pending <= 1'b1;
    end else if (pending) begin
      pending <= 1'b0;
      valid_o <= start_reg[0] && (new_size != '0);
      start_o <= win_start(start_reg);
      size_o  <= new_size;
      port_o  <= route_reg[PORT_W-1:0];
    end
  end

  AST_TOUCH_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> !valid_o); // R10
  AST_VALID_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> size_o != '0); // R6
  AST_START_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (start_o[DATA_W-1:SIZE_W] == '1) && (start_o[PAGE_BITS-1:0] == '0)); // R8
  AST_SIZE_PAGED: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> size_o[PAGE_BITS-1:0] == '0); // R7
  AST_PORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> $stable(port_o)); // R9

endmodule

// File: rtl/mrr_matcher.sv
module mrr_matcher
  import mrr_pkg::*;
#(
  parameter int N_RANGES = 4,
  parameter int PORT_W   = 2
) (
  input  logic [DATA_W-1:0]   addr,
  input  logic [N_RANGES-1:0] valid,
  input  logic [DATA_W-1:0]   start [N_RANGES],
  input  logic [SIZE_W-1:0]   size  [N_RANGES],
  input  logic [PORT_W-1:0]   port  [N_RANGES],
  output logic                hit,
  output logic [PORT_W-1:0]   port_o
);

  logic [N_RANGES-1:0] match;

  for (genvar r = 0; r < N_RANGES; r++) begin : g_cmp
    assign match[r] = valid[r] && win_contains(addr, start[r], size[r]);
  end

  // Walk from the top so the lowest matching index is the last to assign.
  always_comb begin
    hit    = 1'b0;
    port_o = '0;
    for (int r = N_RANGES - 1; r >= 0; r--) begin
      if (match[r]) begin
        hit    = 1'b1;
        port_o = port[r];
      end
    end
  end

endmodule

// File: rtl/mmio_range_router.sv
module mmio_range_router
  import mrr_pkg::*;
#(
  parameter int N_RANGES = 4,
  parameter int N_PORTS  = 4,
  parameter int ADDR_W   = 12,
  parameter int WIN_BASE = 'h300,
  localparam int PORT_W  = $clog2(N_PORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_half,
  input  logic [63:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_half,
  output logic [63:0]       rd_data,
  input  logic [63:0]       lk_addr,
  output logic              lk_hit,
  output logic [PORT_W-1:0] lk_port
);

  logic [DATA_W-1:0]   regs  [3*N_RANGES];
  logic [N_RANGES-1:0] touch;
  logic [N_RANGES-1:0] win_valid;
  logic [DATA_W-1:0]   win_start_q [N_RANGES];
  logic [SIZE_W-1:0]   win_size_q  [N_RANGES];
  logic [PORT_W-1:0]   win_port_q  [N_RANGES];

  mrr_regbank #(
    .N_RANGES(N_RANGES), .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_half(wr_half), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_half(rd_half), .rd_data(rd_data),
    .regs_o(regs), .touch_o(touch)
  );

  for (genvar r = 0; r < N_RANGES; r++) begin : g_win
    mrr_window #(.PORT_W(PORT_W)) u_win (
      .clk(clk), .rst_n(rst_n), .touch(touch[r]),
      .start_reg(regs[3*r]), .mask_reg(regs[3*r+1]), .route_reg(regs[3*r+2]),
      .valid_o(win_valid[r]), .start_o(win_start_q[r]),
      .size_o(win_size_q[r]), .port_o(win_port_q[r])
    );
  end

  mrr_matcher #(.N_RANGES(N_RANGES), .PORT_W(PORT_W)) u_match (
    .addr(lk_addr), .valid(win_valid), .start(win_start_q),
    .size(win_size_q), .port(win_port_q), .hit(lk_hit), .port_o(lk_port)
  );

  AST_MISS_PORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_port == '0); // R12
  AST_NO_VALID_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid == '0) |-> !lk_hit); // R6

endmodule

// File: tb/tb_mmio_range_router.sv
module tb_mmio_range_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic        wr_half = 1'b0;
  logic [63:0] wr_data = '0;
  logic [11:0] rd_addr = '0;
  logic        rd_half = 1'b0;
  logic [63:0] rd_data;
  logic [63:0] lk_addr = '0;
  logic        lk_hit;
  logic [1:0]  lk_port;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  mmio_range_router dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_half(wr_half), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_half(rd_half), .rd_data(rd_data),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_port(lk_port)
  );

  // Lookup vectors after programming: {hit, port}
  localparam int NV = 10;
  localparam logic [63:0] VA [NV] = '{
    64'hFFFF_FFFF_F000_0000,  // R7 first byte of range 0
    64'hFFFF_FFFF_F0FF_FFFF,  // R7 last byte of range 0
    64'hFFFF_FFFF_F0F9_0000,  // R11 overlap of 0 and 1, range 0 wins
    64'hFFFF_FFFF_F100_0000,  // R9 range 1 only
    64'hFFFF_FFFF_F107_FFFF,  // R7 last byte of range 1
    64'hFFFF_FFFF_F108_0000,  // R12 one past range 1
    64'h0000_0000_F000_0000,  // R8 upper half not all ones
    64'hFFFF_FFFF_EFFF_FFFF,  // R12 just below range 0
    64'hFFFF_FFFF_E000_0100,  // R6 range 2 enable bit clear
    64'hFFFF_FFFF_D000_0000   // R6 range 3 size rounds to zero
  };
  localparam logic [2:0] VE [NV] = '{
    3'b110, 3'b110, 3'b110, 3'b101, 3'b101,
    3'b000, 3'b000, 3'b000, 3'b000, 3'b000
  };

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic h);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_half = h;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [11:0] a, input logic h,
                          input logic [63:0] exp);
    rd_addr = a; rd_half = h;
    #1;
    check64(tag, rd_data, exp);
  endtask

  task automatic lk_check(input string tag, input logic [63:0] a, input logic eh,
                          input logic [1:0] ep);
    lk_addr = a;
    #1;
    check64(tag, {61'b0, lk_hit, lk_port}, {61'b0, eh, ep});
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int k = 0; k < 12; k++) rd_check("R1 reset read", 12'h300 + 12'(8*k), 1'b0, 64'h0);
    lk_check("R1 reset lookup", 64'hFFFF_FFFF_F000_0000, 1'b0, 2'd0);

    // Program all four ranges (R5 layout: start, mask, route per range)
    wr(12'h300, 64'h0000_0000_F000_0001, 1'b0);
    wr(12'h308, 64'hFFFF_FFFF_FF00_0000, 1'b0);
    wr(12'h310, 64'd6, 1'b0);
    wr(12'h318, 64'h0000_0000_F0F8_0001, 1'b0);
    wr(12'h320, 64'h0000_0000_FFF0_0000, 1'b0);
    wr(12'h328, 64'd5, 1'b0);
    wr(12'h330, 64'h0000_0000_E000_0000, 1'b0);
    wr(12'h338, 64'h0000_0000_FFFF_0000, 1'b0);
    wr(12'h340, 64'd3, 1'b0);
    wr(12'h348, 64'h1234_5678_D000_0ABD, 1'b0);
    wr(12'h350, 64'h0000_0000_FFFF_F800, 1'b0);
    wr(12'h358, 64'd7, 1'b0);
    @(negedge clk);

    // Table walk: R6 R7 R8 R9 R11 R12
    for (int i = 0; i < NV; i++) begin
      lk_addr = VA[i];
      #1;
      checks++;
      if ({lk_hit, lk_port} !== VE[i]) begin
        failures++;
        $display("FAIL R7/R11/R12 vector %0d actual=%b expected=%b", i, {lk_hit, lk_port}, VE[i]);
      end
    end

    // R2: full readback
    rd_check("R2 full read", 12'h348, 1'b0, 64'h1234_5678_D000_0ABD);
    // R4: half reads
    rd_check("R4 half read low", 12'h348, 1'b1, 64'h0000_0000_D000_0ABD);
    rd_check("R4 half read high", 12'h34C, 1'b1, 64'h0000_0000_1234_5678);

    // R3: half writes
    wr(12'h340, 64'h1111_2222_3333_4444, 1'b0);
    wr(12'h340, 64'hFFFF_FFFF_AAAA_BBBB, 1'b1);
    rd_check("R3 low half write", 12'h340, 1'b0, 64'h1111_2222_AAAA_BBBB);
    wr(12'h344, 64'h0000_0000_CCCC_DDDD, 1'b1);
    rd_check("R3 high half write", 12'h340, 1'b0, 64'hCCCC_DDDD_AAAA_BBBB);

    // R5: outside the register window
    wr(12'h360, 64'hDEAD_BEEF_DEAD_BEEF, 1'b0);
    rd_check("R5 read past window", 12'h360, 1'b0, 64'h0);
    wr(12'h2F8, 64'hDEAD_BEEF_DEAD_BEEF, 1'b0);
    rd_check("R5 read below window", 12'h2F8, 1'b0, 64'h0);
    rd_check("R5 neighbour intact", 12'h300, 1'b0, 64'h0000_0000_F000_0001);
    rd_check("R5 last reg intact", 12'h358, 1'b0, 64'd7);
    lk_check("R5 mapping intact", 64'hFFFF_FFFF_F000_0000, 1'b1, 2'd2);

    // R10 + R9: rewrite range 0 route, window drops then returns on port 1
    wr(12'h310, 64'hFFFF_FFFF_FFFF_FFF1, 1'b0);
    lk_check("R10 disabled after write", 64'hFFFF_FFFF_F000_0000, 1'b0, 2'd0);
    @(negedge clk);
    lk_check("R9 route modulo ports", 64'hFFFF_FFFF_F000_0000, 1'b1, 2'd1);

    // R7 + R6: range 3 gets a two-page size
    wr(12'h350, 64'h0000_0000_FFFF_E000, 1'b0);
    lk_check("R10 range 3 pending", 64'hFFFF_FFFF_D000_0000, 1'b0, 2'd0);
    @(negedge clk);
    lk_check("R7 range 3 first", 64'hFFFF_FFFF_D000_0000, 1'b1, 2'd3);
    lk_check("R7 range 3 last", 64'hFFFF_FFFF_D000_1FFF, 1'b1, 2'd3);
    lk_check("R7 range 3 end", 64'hFFFF_FFFF_D000_2000, 1'b0, 2'd0);
    lk_check("R8 below range 3", 64'hFFFF_FFFF_CFFF_FFFF, 1'b0, 2'd0);

    // R6: clearing the enable bit removes range 3
    wr(12'h348, 64'h0000_0000_D000_0000, 1'b0);
    @(negedge clk);
    lk_check("R6 enable cleared", 64'hFFFF_FFFF_D000_0000, 1'b0, 2'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule